// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps a CAN node's transmit error count (TEC) and receive error count (REC) and derives from them the node's fault state: error active, error passive or bus off. The protocol engine next to it classifies what happened on the bus. It delivers one-cycle event pulses: an ordinary protocol error with its qualifiers, a bit error while an active error flag is being sent, a dominant first bit after a flag, the end of a flag, and a good transmission or reception. It also delivers every sampled bus bit with a strobe. This block applies the counting rules to those inputs and reports the resulting state.

The outputs are the fault state, both counter values, a select that tells the engine to send a passive (recessive) rather than an active (dominant) error flag, and a driver-disable that is raised while the node is bus off. The block watches the bus bits itself to count runs of dominant bits after an error flag and to time the way out of bus off.

A mode input picks one of two recovery rules. In the first, a fixed total number of recessive bits is enough. In the second, a fixed number of runs of consecutive recessive bits is needed, each run marking a frame that completed without error on the bus.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, TEC and REC are 0, the state is error active (code 0), and the flag select and driver-disable are both 0.
- R2: The state is error passive (code 1), with the flag select at 1, while TEC or REC is at least 128 and the node is not bus off. The state returns to error active (code 0) as soon as both counters are below 128.
- R3: When TEC exceeds 255, the state is bus off (code 2) and the driver-disable is 1. While the node is bus off, no event changes TEC or REC.
- R4: An ordinary protocol error (the ev_err pulse) adds 8 to TEC when is_tx is 1. It adds 1 to REC when is_tx is 0.
- R5: A transmitter error leaves TEC unchanged when err_arb_stuff is 1. It also leaves TEC unchanged when err_ack_nodom is 1 and the node is error passive. When the node is error active, err_ack_nodom has no effect.
- R6: A bit error while sending an active error flag adds 8 to TEC if is_tx is 1 and to REC otherwise. A dominant first bit after a flag adds 8 to REC for a receiver and has no effect for a transmitter.
- R7: After the end of a flag, each strobed dominant bit (bit_val 0) extends a run. The counter selected by is_tx gains 8 when the run reaches 14 bits after an active flag or 8 bits after a passive flag (flag_was_passive 1). It gains a further 8 for every 8 dominant bits after that. A recessive bit ends the run.
- R8: A good transmission decrements TEC by 1 and a good reception decrements REC by 1. A counter already at 0 stays at 0.
- R9: REC saturates at 255 and never wraps.
- R10: With mode_enh at 0, bus off ends on the RECOV_COUNT×11-th strobed recessive bit. Dominant bits in between do not restart the count.
- R11: With mode_enh at 1, bus off ends when RECOV_COUNT runs of 11 consecutive recessive bits have completed. A dominant bit discards the run in progress.
- R12: On leaving bus off, TEC and REC are both 0 and the state is error active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_enh | input | 1 | Recovery rule: 0 total recessive bits, 1 runs of recessive bits |
| is_tx | input | 1 | Node is the transmitter of the current frame |
| ev_err | input | 1 | Stuff, form, CRC or ACK error pulse |
| err_arb_stuff | input | 1 | Qualifier: stuff error in arbitration on a recessive stuff bit |
| err_ack_nodom | input | 1 | Qualifier: ACK error with no dominant bit during the passive flag |
| ev_flag_bit_err | input | 1 | Bit error while sending an active error flag |
| ev_first_dom | input | 1 | First bit after an error flag was dominant |
| ev_flag_end | input | 1 | An error or overload flag has just ended |
| flag_was_passive | input | 1 | Qualifier of ev_flag_end: the flag was passive |
| ev_tx_ok | input | 1 | Good transmission |
| ev_rx_ok | input | 1 | Good reception |
| bit_strobe | input | 1 | Sampled bus bit valid |
| bit_val | input | 1 | Sampled bus bit, 1 recessive, 0 dominant |
| state | output | 2 | 0 error active, 1 error passive, 2 bus off |
| tec | output | TEC_W | Transmit error count |
| rec | output | REC_W | Receive error count |
| flag_passive_sel | output | 1 | 1: send a passive error flag |
| drv_off | output | 1 | Bus driver disabled (bus off) |

## Verification
The bench keeps every counting threshold at its working value: 14 and 8 bit dominant runs, the 128 passive boundary, the 255 bus-off boundary and 11-bit recovery runs. These boundaries are therefore crossed exactly as they would be in service. Only RECOV_COUNT is lowered to 4, which brings both recovery rules within a few dozen strobed bits. That makes room to place dominant bits inside the recovery window and show that one rule ignores them while the other starts its run again.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/fc_event_decode.sv
module fc_event_decode #(
  parameter int INC_W       = 6,
  parameter int TX_ERR_INC  = 8,
  parameter int RX_ERR_INC  = 1,
  parameter int FLAG_INC    = 8
) (
  input  logic             is_tx,
  input  logic             is_passive,
  input  logic             ev_err,
  input  logic             err_arb_stuff,
  input  logic             err_ack_nodom,
  input  logic             ev_flag_bit_err,
  input  logic             ev_first_dom,
  input  logic             dom_add,
  input  logic             ev_tx_ok,
  input  logic             ev_rx_ok,
  output logic [INC_W-1:0] tec_add,
  output logic [INC_W-1:0] rec_add,
  output logic             tec_dec,
  output logic             rec_dec,
  output logic             tx_err_exempt
);
  localparam logic [INC_W-1:0] TX_I = INC_W'(TX_ERR_INC);
  localparam logic [INC_W-1:0] RX_I = INC_W'(RX_ERR_INC);
  localparam logic [INC_W-1:0] FL_I = INC_W'(FLAG_INC);

  logic tx_err_counts;
  logic rx_err_counts;

  always_comb begin
    tx_err_exempt = err_arb_stuff | (err_ack_nodom & is_passive);
    tx_err_counts = ev_err & is_tx & ~tx_err_exempt;
    rx_err_counts = ev_err & ~is_tx;
    tec_add = (tx_err_counts              ? TX_I : '0)
            + ((ev_flag_bit_err & is_tx)   ? FL_I : '0)
            + ((dom_add & is_tx)           ? FL_I : '0);
    rec_add = (rx_err_counts              ? RX_I : '0)
            + ((ev_flag_bit_err & ~is_tx)  ? FL_I : '0)
            + ((ev_first_dom & ~is_tx)     ? FL_I : '0)
            + ((dom_add & ~is_tx)          ? FL_I : '0);
    tec_dec = ev_tx_ok;
    rec_dec = ev_rx_ok;
  end
endmodule

// File: rtl/fc_dom_monitor.sv
module fc_dom_monitor #(
  parameter int DOM_RUN_ACTIVE  = 14,
  parameter int DOM_RUN_PASSIVE = 8,
  parameter int DOM_RUN_STEP    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_end,
  input  logic flag_passive,
  input  logic bit_strobe,
  input  logic bit_val,
  output logic dom_add
);
  localparam int MAXR = (DOM_RUN_ACTIVE > DOM_RUN_PASSIVE) ?
                        ((DOM_RUN_ACTIVE > DOM_RUN_STEP) ? DOM_RUN_ACTIVE : DOM_RUN_STEP) :
                        ((DOM_RUN_PASSIVE > DOM_RUN_STEP) ? DOM_RUN_PASSIVE : DOM_RUN_STEP);
  localparam int DW = $clog2(MAXR + 1);
  localparam logic [DW-1:0] TH_ACT  = DW'(DOM_RUN_ACTIVE);
  localparam logic [DW-1:0] TH_PAS  = DW'(DOM_RUN_PASSIVE);
  localparam logic [DW-1:0] TH_STEP = DW'(DOM_RUN_STEP);

  logic          armed_q;
  logic          first_q;
  logic          pas_q;
  logic [DW-1:0] run_q;
  logic [DW-1:0] thr;
  logic [DW-1:0] run_inc;
  logic          dom_bit;

  always_comb begin
    if (first_q) thr = pas_q ? TH_PAS : TH_ACT;
    else         thr = TH_STEP;
    run_inc = run_q + DW'(1);
    dom_bit = armed_q & ~flag_end & bit_strobe & ~bit_val;
    dom_add = dom_bit & (run_inc == thr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      first_q <= 1'b1;
      pas_q   <= 1'b0;
      run_q   <= '0;
    end else if (flag_end) begin
      armed_q <= 1'b1;
      first_q <= 1'b1;
      pas_q   <= flag_passive;
      run_q   <= '0;
    end else if (armed_q && bit_strobe) begin
      if (bit_val) begin
        armed_q <= 1'b0;
        run_q   <= '0;
      end else if (dom_add) begin
        first_q <= 1'b0;
        run_q   <= '0;
      end else begin
        run_q   <= run_inc;
      end
    end
  end
endmodule

// File: rtl/fc_err_counters.sv
module fc_err_counters #(
  parameter int TEC_W = 9,
  parameter int REC_W = 8,
  parameter int INC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             clear,
  input  logic [INC_W-1:0] tec_add,
  input  logic [INC_W-1:0] rec_add,
  input  logic             tec_dec,
  input  logic             rec_dec,
  output logic [TEC_W-1:0] tec,
  output logic [REC_W-1:0] rec
);
  localparam logic [REC_W-1:0] REC_MAX = '1;

  function automatic logic [TEC_W-1:0] f_tec_next(
    input logic [TEC_W-1:0] cur, input logic [INC_W-1:0] add, input logic dec);
    if (add != '0)                return cur + {{(TEC_W-INC_W){1'b0}}, add};
    else if (dec && cur != '0)    return cur - TEC_W'(1);
    else                          return cur;
  endfunction

  function automatic logic [REC_W-1:0] f_rec_next(
    input logic [REC_W-1:0] cur, input logic [INC_W-1:0] add, input logic dec);
    logic [REC_W:0] sum;
    sum = {1'b0, cur} + {{(REC_W+1-INC_W){1'b0}}, add};
    if (add != '0)                return sum[REC_W] ? REC_MAX : sum[REC_W-1:0];
    else if (dec && cur != '0)    return cur - REC_W'(1);
    else                          return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      tec <= '0;
      rec <= '0;
    end else if (!freeze) begin
      tec <= f_tec_next(tec, tec_add, tec_dec);
      rec <= f_rec_next(rec, rec_add, rec_dec);
    end
  end
endmodule

// File: rtl/fc_recovery.sv
module fc_recovery #(
  parameter int RECOV_BITS  = 11,
  parameter int RECOV_COUNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busoff,
  input  logic mode_enh,
  input  logic bit_strobe,
  input  logic bit_val,
  output logic done
);
  localparam int RW = $clog2(RECOV_BITS + 1);
  localparam int GW = $clog2(RECOV_COUNT + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(RECOV_BITS - 1);
  localparam logic [GW-1:0] GRP_LAST = GW'(RECOV_COUNT - 1);

  logic [RW-1:0] run_q;
  logic [GW-1:0] grp_q;
  logic          rec_bit;
  logic          run_full;

  always_comb begin
    rec_bit  = busoff & bit_strobe & bit_val;
    run_full = rec_bit & (run_q == RUN_LAST);
    done     = run_full & (grp_q == GRP_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !busoff || done) begin
      run_q <= '0;
      grp_q <= '0;
    end else if (bit_strobe) begin
      if (run_full) begin
        run_q <= '0;
        grp_q <= grp_q + GW'(1);
      end else if (rec_bit) begin
        run_q <= run_q + RW'(1);
      end else if (mode_enh) begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import fc_pkg::*;
#(
  parameter int TEC_W           = 9,
  parameter int REC_W           = 8,
  parameter int PASSIVE_AT      = 128,
  parameter int BUSOFF_ABOVE    = 255,
  parameter int TX_ERR_INC      = 8,
  parameter int RX_ERR_INC      = 1,
  parameter int FLAG_INC        = 8,
  parameter int DOM_RUN_ACTIVE  = 14,
  parameter int DOM_RUN_PASSIVE = 8,
  parameter int DOM_RUN_STEP    = 8,
  parameter int RECOV_BITS      = 11,
  parameter int RECOV_COUNT     = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_enh,
  input  logic             is_tx,
  input  logic             ev_err,
  input  logic             err_arb_stuff,
  input  logic             err_ack_nodom,
  input  logic             ev_flag_bit_err,
  input  logic             ev_first_dom,
  input  logic             ev_flag_end,
  input  logic             flag_was_passive,
  input  logic             ev_tx_ok,
  input  logic             ev_rx_ok,
  input  logic             bit_strobe,
  input  logic             bit_val,
  output logic [1:0]       state,
  output logic [TEC_W-1:0] tec,
  output logic [REC_W-1:0] rec,
  output logic             flag_passive_sel,
  output logic             drv_off
);
  localparam int INC_W = $clog2(TX_ERR_INC + RX_ERR_INC + 3*FLAG_INC + 1);
  localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_AT);
  localparam logic [TEC_W-1:0] TEC_BO   = TEC_W'(BUSOFF_ABOVE);
  localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_AT);

  // named internal events, visible to the checker and waveforms
  logic             busoff_w;
  logic             passive_w;
  logic             dom_add_w;
  logic             recov_done_w;
  logic             tx_exempt_w;
  logic [INC_W-1:0] tec_add_w;
  logic [INC_W-1:0] rec_add_w;
  logic             tec_dec_w;
  logic             rec_dec_w;
  fc_state_e        state_e;

  always_comb begin
    busoff_w  = tec > TEC_BO;
    passive_w = ~busoff_w & ((tec >= TEC_PASS) | (rec >= REC_PASS));
    if (busoff_w)       state_e = FC_BUSOFF;
    else if (passive_w) state_e = FC_PASSIVE;
    else                state_e = FC_ACTIVE;
    state            = state_e;
    flag_passive_sel = passive_w;
    drv_off          = busoff_w;
  end

  fc_event_decode #(
    .INC_W(INC_W), .TX_ERR_INC(TX_ERR_INC),
    .RX_ERR_INC(RX_ERR_INC), .FLAG_INC(FLAG_INC)
  ) u_dec (
    .is_tx(is_tx), .is_passive(passive_w), .ev_err(ev_err),
    .err_arb_stuff(err_arb_stuff), .err_ack_nodom(err_ack_nodom),
    .ev_flag_bit_err(ev_flag_bit_err), .ev_first_dom(ev_first_dom),
    .dom_add(dom_add_w), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
    .tec_add(tec_add_w), .rec_add(rec_add_w),
    .tec_dec(tec_dec_w), .rec_dec(rec_dec_w), .tx_err_exempt(tx_exempt_w)
  );

  fc_dom_monitor #(
    .DOM_RUN_ACTIVE(DOM_RUN_ACTIVE), .DOM_RUN_PASSIVE(DOM_RUN_PASSIVE),
    .DOM_RUN_STEP(DOM_RUN_STEP)
  ) u_dom (
    .clk(clk), .rst_n(rst_n), .flag_end(ev_flag_end),
    .flag_passive(flag_was_passive), .bit_strobe(bit_strobe),
    .bit_val(bit_val), .dom_add(dom_add_w)
  );

  fc_err_counters #(
    .TEC_W(TEC_W), .REC_W(REC_W), .INC_W(INC_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .freeze(busoff_w), .clear(recov_done_w),
    .tec_add(tec_add_w), .rec_add(rec_add_w),
    .tec_dec(tec_dec_w), .rec_dec(rec_dec_w),
    .tec(tec), .rec(rec)
  );

  fc_recovery #(
    .RECOV_BITS(RECOV_BITS), .RECOV_COUNT(RECOV_COUNT)
  ) u_rcv (
    .clk(clk), .rst_n(rst_n), .busoff(busoff_w), .mode_enh(mode_enh),
    .bit_strobe(bit_strobe), .bit_val(bit_val), .done(recov_done_w)
  );
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int TEC_W      = 9,
  parameter int REC_W      = 8,
  parameter int PASSIVE_AT = 128,
  parameter int MAX_STEP   = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       state,
  input logic [TEC_W-1:0] tec,
  input logic [REC_W-1:0] rec,
  input logic             flag_passive_sel,
  input logic             drv_off
);
  localparam logic [TEC_W-1:0] TP = TEC_W'(PASSIVE_AT);
  localparam logic [REC_W-1:0] RP = REC_W'(PASSIVE_AT);
  localparam logic [REC_W-1:0] RTOP = '1;
  localparam logic [REC_W-1:0] RNEAR = RTOP - REC_W'(8);
  localparam logic [TEC_W-1:0] STEP = TEC_W'(MAX_STEP);

  assert_passive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1) |-> (flag_passive_sel && !drv_off && (tec >= TP || rec >= RP)));

  assert_busoff_drv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2) |-> (drv_off && !flag_passive_sel));

  assert_busoff_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drv_off) && drv_off) |-> ($stable(rec) && $stable(tec)));

  assert_tec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(drv_off) && tec > $past(tec)) |-> ((tec - $past(tec)) <= STEP));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(drv_off) && $past(rec) > RNEAR) |-> (rec >= RNEAR));

  assert_clear_exit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drv_off) && !drv_off) |-> (tec == '0 && rec == '0 && state == 2'd0));
endmodule

bind can_fault_conf fc_checker #(
  .TEC_W(TEC_W), .REC_W(REC_W), .PASSIVE_AT(PASSIVE_AT),
  .MAX_STEP(TX_ERR_INC + 2*FLAG_INC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .tec(tec), .rec(rec),
  .flag_passive_sel(flag_passive_sel), .drv_off(drv_off)
);

// File: tb/can_fault_conf_tb.sv
module can_fault_conf_tb;
  logic clk, rst_n;
  logic mode_enh, is_tx, ev_err, err_arb_stuff, err_ack_nodom;
  logic ev_flag_bit_err, ev_first_dom, ev_flag_end, flag_was_passive;
  logic ev_tx_ok, ev_rx_ok, bit_strobe, bit_val;
  logic [1:0] state;
  logic [8:0] tec;
  logic [7:0] rec;
  logic flag_passive_sel, drv_off;
  int checks = 0;
  int errors = 0;

  can_fault_conf #(.RECOV_COUNT(4)) u_dut (.*);

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_err = 0; err_arb_stuff = 0; err_ack_nodom = 0; ev_flag_bit_err = 0;
    ev_first_dom = 0; ev_flag_end = 0; flag_was_passive = 0;
    ev_tx_ok = 0; ev_rx_ok = 0; bit_strobe = 0; bit_val = 1;
  endtask

  task automatic do_reset();
    rst_n = 0; idle_inputs(); is_tx = 0; mode_enh = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic err(input logic tx, input logic arb, input logic acknd);
    is_tx = tx; ev_err = 1; err_arb_stuff = arb; err_ack_nodom = acknd;
    @(negedge clk); idle_inputs();
  endtask

  task automatic flagbit(input logic tx);
    is_tx = tx; ev_flag_bit_err = 1; @(negedge clk); idle_inputs();
  endtask

  task automatic firstdom(input logic tx);
    is_tx = tx; ev_first_dom = 1; @(negedge clk); idle_inputs();
  endtask

  task automatic flag_end(input logic pas);
    ev_flag_end = 1; flag_was_passive = pas; @(negedge clk); idle_inputs();
  endtask

  task automatic ok(input logic tx);
    if (tx) ev_tx_ok = 1; else ev_rx_ok = 1;
    @(negedge clk); idle_inputs();
  endtask

  task automatic send_bit(input logic v);
    bit_strobe = 1; bit_val = v; @(negedge clk); idle_inputs();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tec", tec, 0); chk("R1 rec", rec, 0); chk("R1 state", state, 0);
    chk("R1 flag_sel", flag_passive_sel, 0); chk("R1 drv_off", drv_off, 0);
  endtask

  task automatic t_basic();
    do_reset();
    repeat (3) err(0, 0, 0);
    chk("R4 rx err rec", rec, 3); chk("R4 rx err tec", tec, 0);
    err(1, 0, 0);
    chk("R4 tx err tec", tec, 8); chk("R4 tx err rec", rec, 3);
    err(1, 1, 0);
    chk("R5 arb stuff exempt", tec, 8);
    ok(0); chk("R8 rx ok", rec, 2);
    ok(1); chk("R8 tx ok", tec, 7);
    repeat (8) ok(1);
    chk("R8 tec floor", tec, 0);
    flagbit(1); chk("R6 flag bit err tx", tec, 8);
    flagbit(0); chk("R6 flag bit err rx", rec, 10);
    firstdom(0); chk("R6 first dom rx", rec, 18);
    firstdom(1); chk("R6 first dom tx rec", rec, 18);
    chk("R6 first dom tx tec", tec, 8);
  endtask

  task automatic t_domrun();
    do_reset();
    is_tx = 0; flag_end(0);
    repeat (13) send_bit(0);
    chk("R7 13 dom", rec, 0);
    send_bit(0); chk("R7 14th dom", rec, 8);
    repeat (7) send_bit(0);
    chk("R7 +7 dom", rec, 8);
    send_bit(0); chk("R7 +8 dom", rec, 16);
    send_bit(1); repeat (20) send_bit(0);
    chk("R7 run ended", rec, 16);
    is_tx = 1; flag_end(1);
    repeat (7) send_bit(0);
    chk("R7 passive 7", tec, 0);
    send_bit(0); chk("R7 passive 8th tec", tec, 8);
    chk("R7 passive rec", rec, 16);
  endtask

  task automatic t_passive();
    do_reset();
    repeat (15) err(1, 0, 0);
    chk("R2 tec 120 state", state, 0);
    err(1, 0, 0);
    chk("R2 tec 128", tec, 128); chk("R2 passive", state, 1);
    chk("R2 flag_sel", flag_passive_sel, 1);
    err(1, 0, 1); chk("R5 ack exempt passive", tec, 128);
    ok(1); chk("R2 back active", state, 0);
    chk("R2 flag_sel clr", flag_passive_sel, 0);
    err(1, 0, 1); chk("R5 ack not exempt active", tec, 135);
    do_reset();
    repeat (16) firstdom(0);
    chk("R2 rec passive", state, 1);
  endtask

  task automatic t_rec_sat();
    do_reset();
    repeat (32) firstdom(0);
    chk("R9 rec sat", rec, 255);
    err(0, 0, 0); chk("R9 rec hold", rec, 255);
  endtask

  task automatic go_busoff();
    do_reset();
    repeat (5) err(0, 0, 0);
    repeat (31) err(1, 0, 0);
    chk("R3 tec 248 not off", drv_off, 0);
    err(1, 0, 0);
    chk("R3 busoff state", state, 2); chk("R3 drv_off", drv_off, 1);
    chk("R3 flag_sel off", flag_passive_sel, 0);
    err(0, 0, 0); chk("R3 rec frozen", rec, 5);
    ok(1); chk("R3 tec frozen", tec, 256);
  endtask

  task automatic t_recover_std();
    go_busoff();
    mode_enh = 0;
    for (int i = 0; i < 43; i++) begin
      send_bit(1);
      if (i % 5 == 0) send_bit(0);
    end
    chk("R10 43 rec bits", state, 2);
    send_bit(1);
    chk("R10 recovered", state, 0);
    chk("R12 tec clr", tec, 0); chk("R12 rec clr", rec, 0);
    chk("R12 drv_off", drv_off, 0);
  endtask

  task automatic t_recover_enh();
    go_busoff();
    mode_enh = 1;
    repeat (10) send_bit(1);
    send_bit(0);
    repeat (43) send_bit(1);
    chk("R11 not yet", state, 2);
    send_bit(1);
    chk("R11 recovered", state, 0);
    chk("R12 tec clr enh", tec, 0); chk("R12 rec clr enh", rec, 0);
  endtask

  initial begin
    rst_n = 0; is_tx = 0; mode_enh = 0; idle_inputs();
    t_reset();
    t_basic();
    t_domrun();
    t_passive();
    t_rec_sat();
    t_recover_std();
    t_recover_enh();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule